// File: doc/BRIEF.md
# Pairable PWM Generator Bank

This block holds four 8-bit pulse-width modulators, each driving its own output pin. Every channel counts ticks from 0 up to its period minus one and drives its pin high for the first "duty" counts of each period. The counter advances on one of two single-cycle tick sources: a time-base tick or the overflow pulse of an external 8-bit reload timer, chosen by one control bit shared by all channels.

Channels 0/1 and 2/3 can each be joined into one 16-bit modulator. The upper channel's period and duty registers then form the high byte, and its own pin stays low. A joined pair has a high-speed mode for D/A use. The frame is fixed at 65536 ticks, split into 256 sub-periods of 256 ticks each. Every sub-period carries the same base pulse, and single extra counts are spread evenly across the frame, which keeps the ripple after a low-pass filter small.

Period and duty writes go to buffers. They take effect only when the running period ends, or when the control register is written, so a partly updated setting never reaches a pin.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output pin is low, and all period, duty and control registers are zero.
- R2: In unpaired use a channel with period P counts 0..P-1 (P=0 counts 256) and advances once per selected tick. Its pin is high while the count is below the duty D, so it is high for D of every P ticks.
- R3: A duty of 0 keeps the pin low. A duty greater than or equal to a nonzero period keeps the pin high.
- R4: Period and duty writes are buffered. They are applied only at the end of the period in progress, so the current period completes with its old values.
- R5: Control bit 0 selects the tick source: 0 selects `tick_base`, 1 selects `tick_ovf`. The other source is ignored, and no counter moves without a selected tick.
- R6: Control bit 1 joins channels 0/1 and bit 2 joins channels 2/3. A joined pair uses {upper, lower} period and duty as 16-bit values, drives the lower channel's pin as one 16-bit modulator, and holds the upper channel's pin low.
- R7: Control bit 3 (pair 0/1) and bit 4 (pair 2/3) select high-speed mode, which applies only while the pair is joined. The frame is 65536 ticks, in 256 sub-periods s of 256 ticks. Each sub-period is high for the upper duty byte Dh ticks, plus one more tick when the bit-reversed s is below the lower duty byte Dl. The high total per frame equals the 16-bit duty.
- R8: A write to the control register restarts every counter from zero and applies the buffered period and duty values at once.
- R9: Register map on the 4-bit address: 0..3 hold the periods of channels 0..3, 4..7 hold the duties of channels 0..3, and 8 holds the control register. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_base | input | 1 | Time-base tick, one cycle wide |
| tick_ovf | input | 1 | Reload-timer overflow pulse, one cycle wide |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| pwm_o | output | 4 | PWM pins, bit n for channel n |

## Verification
The critical overlap is a buffer write that lands in the same cycle as, or just before, the end of the running period. That end is also the cycle in which the buffers are applied. The bench provokes this by rewriting a duty in the first tick after a rising edge. It then judges that edge's high run by the old duty and the following run by the new one. A control write that restarts the counters is also placed right after a duty write. The bench checks that the new duty appears within two cycles, not after a full period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Kind of register a bus address hits
  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_PER,
    ACC_DUT,
    ACC_CTL
  } acc_e;

  // Control bit positions
  localparam int CTL_SEL = 0;

  function automatic int join_bit(input int pair);
    return 1 + pair;
  endfunction

  function automatic int hs_bit(input int pair, input int npair);
    return 1 + npair + pair;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int W     = 8,
  parameter int AW    = 4,
  parameter int NCH   = 4,
  parameter int CTLW  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [W-1:0]            wdata,
  output logic [NCH-1:0][W-1:0]   per_sh,
  output logic [NCH-1:0][W-1:0]   dut_sh,
  output logic [CTLW-1:0]         ctl,
  output logic                    restart
);
  import pwm_pkg::*;

  localparam int CTL_ADDR = 2 * NCH;

  logic [NCH-1:0][W-1:0] per_q, per_d, dut_q, dut_d;
  logic [CTLW-1:0]       ctl_q, ctl_d;
  acc_e                  acc;

  always_comb begin
    acc = ACC_NONE;
    if (int'(addr) < NCH)              acc = ACC_PER;
    else if (int'(addr) < 2 * NCH)     acc = ACC_DUT;
    else if (int'(addr) == CTL_ADDR)   acc = ACC_CTL;
  end

  always_comb begin
    per_d = per_q;
    dut_d = dut_q;
    ctl_d = ctl_q;
    if (we) begin
      for (int k = 0; k < NCH; k++) begin
        if (acc == ACC_PER && int'(addr) == k)       per_d[k] = wdata;
        if (acc == ACC_DUT && int'(addr) == NCH + k) dut_d[k] = wdata;
      end
      if (acc == ACC_CTL) ctl_d = wdata[CTLW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      dut_q <= '0;
      ctl_q <= '0;
    end else if (we) begin
      per_q <= per_d;
      dut_q <= dut_d;
      ctl_q <= ctl_d;
    end
  end

  assign per_sh  = per_q;
  assign dut_sh  = dut_q;
  assign ctl     = ctl_q;
  assign restart = we && (acc == ACC_CTL);

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && acc == ACC_NONE) |=> ($stable(per_q) && $stable(dut_q) && $stable(ctl_q))); // R9
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         restart,
  input  logic         joined,
  input  logic         hs,
  input  logic [W-1:0] per_lo_sh,
  input  logic [W-1:0] per_hi_sh,
  input  logic [W-1:0] dut_lo_sh,
  input  logic [W-1:0] dut_hi_sh,
  output logic         out_lo,
  output logic         out_hi
);
  localparam int W2 = 2 * W;

  function automatic logic [W-1:0] bitrev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic [W-1:0] cl_q, cl_d, ch_q, ch_d;
  logic [W-1:0] pl_q, pl_d, ph_q, ph_d, dl_q, dl_d, dh_q, dh_d;
  logic         ol_q, ol_d, oh_q, oh_d;
  logic         ld_l, ld_h, wrap_l, wrap_h, wrap16, hs_on;
  logic [W2-1:0] cnt16, lim16, nxt16;

  assign hs_on  = joined && hs;
  assign cnt16  = {ch_q, cl_q};
  assign lim16  = hs_on ? {W2{1'b1}} : ({ph_q, pl_q} - W2'(1));
  assign wrap16 = (cnt16 == lim16);
  assign nxt16  = wrap16 ? '0 : (cnt16 + W2'(1));
  assign wrap_l = (cl_q == pl_q - W'(1));
  assign wrap_h = (ch_q == ph_q - W'(1));

  // next state: counters and active settings
  always_comb begin
    cl_d = cl_q;
    ch_d = ch_q;
    ld_l = 1'b0;
    ld_h = 1'b0;
    if (restart) begin
      cl_d = '0;
      ch_d = '0;
      ld_l = 1'b1;
      ld_h = 1'b1;
    end else if (step) begin
      if (joined) begin
        {ch_d, cl_d} = nxt16;
        ld_l = wrap16;
        ld_h = wrap16;
      end else begin
        cl_d = wrap_l ? '0 : cl_q + W'(1);
        ch_d = wrap_h ? '0 : ch_q + W'(1);
        ld_l = wrap_l;
        ld_h = wrap_h;
      end
    end
    pl_d = ld_l ? per_lo_sh : pl_q;
    dl_d = ld_l ? dut_lo_sh : dl_q;
    ph_d = ld_h ? per_hi_sh : ph_q;
    dh_d = ld_h ? dut_hi_sh : dh_q;
  end

  // next state: pins
  always_comb begin
    if (hs_on) begin
      ol_d = (cl_q < dh_q) || ((cl_q == dh_q) && (bitrev(ch_q) < dl_q));
      oh_d = 1'b0;
    end else if (joined) begin
      ol_d = (cnt16 < {dh_q, dl_q});
      oh_d = 1'b0;
    end else begin
      ol_d = (cl_q < dl_q);
      oh_d = (ch_q < dh_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q <= '0;
      ch_q <= '0;
      pl_q <= '0;
      ph_q <= '0;
      dl_q <= '0;
      dh_q <= '0;
      ol_q <= 1'b0;
      oh_q <= 1'b0;
    end else begin
      cl_q <= cl_d;
      ch_q <= ch_d;
      pl_q <= pl_d;
      ph_q <= ph_d;
      dl_q <= dl_d;
      dh_q <= dh_d;
      ol_q <= ol_d;
      oh_q <= oh_d;
    end
  end

  assign out_lo = ol_q;
  assign out_hi = oh_q;

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!joined && dl_q == '0) |=> !ol_q); // R3
  AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!joined && pl_q != '0 && dl_q >= pl_q) |=> ol_q); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!joined && pl_q != '0) |-> (cl_q < pl_q)); // R2
  AST_UPPER_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    joined |=> !oh_q); // R6
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> ($stable(cl_q) && $stable(ch_q))); // R5
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cl_q == '0 && ch_q == '0)); // R8
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int W     = 8,
  parameter int AW    = 4,
  parameter int NPAIR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_base,
  input  logic          tick_ovf,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [2*NPAIR-1:0] pwm_o
);
  import pwm_pkg::*;

  localparam int NCH  = 2 * NPAIR;
  localparam int CTLW = 1 + 2 * NPAIR;

  logic [NCH-1:0][W-1:0] per_sh, dut_sh;
  logic [CTLW-1:0]       ctl;
  logic                  restart, step;

  pwm_regs #(.W(W), .AW(AW), .NCH(NCH), .CTLW(CTLW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .per_sh  (per_sh),
    .dut_sh  (dut_sh),
    .ctl     (ctl),
    .restart (restart)
  );

  assign step = ctl[CTL_SEL] ? tick_ovf : tick_base;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic joined, hs;
    assign joined = ctl[join_bit(p)];
    assign hs     = ctl[hs_bit(p, NPAIR)];

    pwm_pair #(.W(W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .restart   (restart),
      .joined    (joined),
      .hs        (hs),
      .per_lo_sh (per_sh[2*p]),
      .per_hi_sh (per_sh[2*p+1]),
      .dut_lo_sh (dut_sh[2*p]),
      .dut_hi_sh (dut_sh[2*p+1]),
      .out_lo    (pwm_o[2*p]),
      .out_hi    (pwm_o[2*p+1])
    );
  end
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  logic       clk, rst_n, tick_base, tick_ovf, bus_we;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [3:0] pwm_o;
  logic       ovf_run;
  int         n_chk, n_bad;

  pwm_bank u_dut (
    .clk(clk), .rst_n(rst_n), .tick_base(tick_base), .tick_ovf(tick_ovf),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pwm_o(pwm_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // overflow pulse every second cycle when enabled
  always @(negedge clk) tick_ovf <= ovf_run ? ~tick_ovf : 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // caller stands just after a negedge
  task automatic wr(input int a, input int d);
    bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    prev = pwm_o[ch];
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (!prev && pwm_o[ch]) return;
      prev = pwm_o[ch];
    end
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_o[ch]) hi++;
      @(negedge clk);
    end
  endtask

  task automatic run_len(input int ch, input int start, output int len);
    len = start;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (!pwm_o[ch]) return;
      len++;
    end
  endtask

  task automatic t_reset();
    check("R1 pins after reset", int'(pwm_o), 0);
  endtask

  task automatic t_basic();
    int hi;
    wr(0, 10); wr(4, 3);
    wr(1, 7);  wr(5, 5);
    wr(2, 5);  wr(6, 0);
    wr(3, 6);  wr(7, 9);
    wr(8, 0);
    wait_rise(0); count_high(0, 30, hi); check("R2 ch0 10/3", hi, 9);
    wait_rise(1); count_high(1, 21, hi); check("R2 ch1 7/5", hi, 15);
    count_high(2, 50, hi); check("R3 zero duty low", hi, 0);
    count_high(3, 50, hi); check("R3 duty over period high", hi, 50);
  endtask

  task automatic t_buffer();
    int len;
    wait_rise(0);
    wr(4, 6);
    run_len(0, 2, len); check("R4 current period keeps old duty", len, 3);
    wait_rise(0); run_len(0, 1, len); check("R4 next period uses new duty", len, 6);
    wr(12, 8'hFF); wr(15, 8'h01);
    wait_rise(0); run_len(0, 1, len); check("R9 unmapped write ignored", len, 6);
  endtask

  task automatic t_clksel();
    int hi, len;
    wr(8, 1);
    @(negedge clk); @(negedge clk);
    count_high(0, 40, hi); check("R5 base tick ignored, ch0 frozen", hi, 40);
    ovf_run = 1'b1;
    wait_rise(0); run_len(0, 1, len); check("R5 overflow ticks drive count", len, 12);
    ovf_run = 1'b0;
    wr(8, 0);
  endtask

  task automatic t_restart();
    int hi;
    wr(0, 250); wr(4, 0); wr(8, 0);
    @(negedge clk); @(negedge clk);
    wr(4, 100); wr(8, 0);
    count_high(0, 5, hi); check("R8 control write applies duty at once", hi, 4);
  endtask

  task automatic t_pair16();
    int hi;
    wr(0, 8'h20); wr(1, 8'h01); wr(4, 8'h90); wr(5, 8'h00);
    wr(8, 8'h02);
    wait_rise(0);
    fork
      count_high(0, 288, hi);
      begin
        int u;
        count_high(1, 288, u);
        check("R6 upper pin low when joined", u, 0);
      end
    join
    check("R6 16-bit 0x120/0x90", hi, 144);
  endtask

  task automatic t_hispeed();
    int hi, run, r18, r19, up;
    wr(6, 8'h03); wr(7, 8'h12);
    wr(8, 8'h14);
    wait_rise(2);
    hi = 0; run = 0; r18 = 0; r19 = 0; up = 0;
    for (int i = 0; i < 65536; i++) begin
      if (pwm_o[3]) up++;
      if (pwm_o[2]) begin
        hi++; run++;
      end else if (run != 0) begin
        if (run == 18) r18++;
        if (run == 19) r19++;
        run = 0;
      end
      @(negedge clk);
    end
    check("R7 frame high total", hi, 16'h1203);
    check("R7 sub-periods with extra count", r19, 3);
    check("R7 sub-periods with base pulse", r18, 253);
    check("R6 upper pin low in fast mode", up, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; tick_base = 1'b1; ovf_run = 1'b0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_buffer();
    t_clksel();
    t_restart();
    t_pair16();
    t_hispeed();
    finish_up();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end
endmodule